// File: doc/BRIEF.md
# Multi-Core Pin I/O Pipeline

This block sits between a group of processor cores and a bank of physical pins. On the way out, each core holds an output word and a direction (drive-enable) word. A core loads both words when its commit strobe is high, and that strobe marks the last clock of an instruction. Auxiliary per-pin function units and one streaming engine also supply output and direction words, but they feed the merge without any register of their own. A generic OR tree merges every source. The result is registered once in a central stage and drives the pads.

On the way in, the pad levels are registered next to the pins. Per pin, a bypass multiplexer then chooses between the raw pad level and the value offered by the auxiliary function unit. The chosen value is registered again in a central stage that fans it out to all cores. Each core has two read ports with fixed latencies, and both are meant to be counted on by cycle-exact software. The register read port loads from the central stage on the commit strobe, which is the last clock of the preceding instruction. The pin-test port loads straight from the multiplexer on the begin strobe, which is the first clock of an instruction. This makes the pin-test port one clock fresher than the register read port.

Top module: `pio_pipeline`

## Requirements
- R1: While reset is high, and on the first clock after it, pin_out, pin_oe, rd_reg and rd_test are all zero. Every pin is therefore an undriven input, whatever the other inputs do.
- R2: A word presented on a core's out/dir inputs with that core's commit bit high at rising edge E appears on pin_out/pin_oe after edge E+1. Between E and E+1 the pins still show the previous value.
- R3: While a core's commit bit is low, its out/dir inputs have no effect on the pins.
- R4: Each pin_out bit is the OR of the latched output words of all cores, all auxiliary words and the streamer word. The same OR rule applies to pin_oe using the direction words.
- R5: Auxiliary and streamer words present at edge E appear on the pins after edge E, one clock of latency.
- R6: With commit held high, a pad change present at edge E appears on that core's rd_reg after edge E+2 (3 clocks). While commit is low, rd_reg holds.
- R7: With begin held high, a pad change present at edge E appears on that core's rd_test after edge E+1 (2 clocks). While begin is low, rd_test holds.
- R8: For each pin, in_smart_sel bit = 1 feeds smart_in into the input path in place of the registered pad level. Bit = 0 selects the pad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_commit | input | NUM_CORES | Per core: last clock of an instruction; loads out/dir and rd_reg |
| core_begin | input | NUM_CORES | Per core: first clock of an instruction; loads rd_test |
| core_out_wr | input | NUM_CORES*NUM_PINS | Output word of each core, core g at bits g*NUM_PINS |
| core_dir_wr | input | NUM_CORES*NUM_PINS | Direction word of each core, same packing |
| aux_out | input | NUM_AUX*NUM_PINS | Output words from auxiliary pin function units |
| aux_dir | input | NUM_AUX*NUM_PINS | Direction words from auxiliary pin function units |
| strm_out | input | NUM_PINS | Streamer output word |
| strm_dir | input | NUM_PINS | Streamer direction word |
| pin_in | input | NUM_PINS | Pad input levels |
| in_smart_sel | input | NUM_PINS | Per-pin input source select, 1 = smart_in |
| smart_in | input | NUM_PINS | Input value from auxiliary function units |
| pin_out | output | NUM_PINS | Merged, registered pad output level |
| pin_oe | output | NUM_PINS | Merged, registered pad drive enable |
| rd_reg | output | NUM_CORES*NUM_PINS | Per-core register read port (3-clock input latency) |
| rd_test | output | NUM_CORES*NUM_PINS | Per-core pin-test read port (2-clock input latency) |

## Verification
The bench drives inputs and samples outputs at falling edges, so every due time is counted in rising edges after the stimulus is presented. A core write reaches the pins after the second rising edge, and an auxiliary or streamer word after the first. A pad change reaches rd_test after the second rising edge and rd_reg after the third. The directed latency checks sample one edge before each due time and then exactly at it. This shows that the old value still holds and that the new value arrives on the counted edge, neither earlier nor later. In the random phase, a bench model advances on the same edges and is compared after every clock.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int DEF_CORES = 4;
  localparam int DEF_PINS  = 64;
  localparam int DEF_AUX   = 2;

  typedef enum logic {
    IN_FROM_PAD   = 1'b0,
    IN_FROM_SMART = 1'b1
  } in_src_e;
endpackage

// File: rtl/pio_or_merge.sv
module pio_or_merge #(
  parameter int W    = 64,
  parameter int NSRC = 4
) (
  input  logic [NSRC*W-1:0] src,
  output logic [W-1:0]      merged
);
  logic [W-1:0] acc [NSRC+1];

  assign acc[0] = '0;
  for (genvar g = 0; g < NSRC; g++) begin : g_or
    assign acc[g+1] = acc[g] | src[g*W +: W];
  end
  assign merged = acc[NSRC];
endmodule

// File: rtl/pio_in_stage.sv
module pio_in_stage
  import pio_pkg::*;
#(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin_in,
  input  logic [W-1:0] sel,
  input  logic [W-1:0] smart_in,
  output logic [W-1:0] mux_o,
  output logic [W-1:0] hub_q
);
  logic [W-1:0] pad_q;

  always_ff @(posedge clk) begin
    if (rst) pad_q <= '0;
    else     pad_q <= pin_in;
  end

  always_comb begin
    for (int b = 0; b < W; b++) begin
      if (in_src_e'(sel[b]) == IN_FROM_SMART) mux_o[b] = smart_in[b];
      else                                   mux_o[b] = pad_q[b];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) hub_q <= '0;
    else     hub_q <= mux_o;
  end
endmodule

// File: rtl/pio_core_port.sv
module pio_core_port #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         commit,
  input  logic         begin_i,
  input  logic [W-1:0] out_wr,
  input  logic [W-1:0] dir_wr,
  input  logic [W-1:0] hub_in,
  input  logic [W-1:0] fresh_in,
  output logic [W-1:0] out_q,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] rd_reg,
  output logic [W-1:0] rd_test
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_q  <= '0;
      dir_q  <= '0;
      rd_reg <= '0;
    end else if (commit) begin
      out_q  <= out_wr;
      dir_q  <= dir_wr;
      rd_reg <= hub_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          rd_test <= '0;
    else if (begin_i) rd_test <= fresh_in;
  end
endmodule

// File: rtl/pio_pipeline.sv
module pio_pipeline
  import pio_pkg::*;
#(
  parameter int NUM_CORES = DEF_CORES,
  parameter int NUM_PINS  = DEF_PINS,
  parameter int NUM_AUX   = DEF_AUX
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_CORES-1:0]          core_commit,
  input  logic [NUM_CORES-1:0]          core_begin,
  input  logic [NUM_CORES*NUM_PINS-1:0] core_out_wr,
  input  logic [NUM_CORES*NUM_PINS-1:0] core_dir_wr,
  input  logic [NUM_AUX*NUM_PINS-1:0]   aux_out,
  input  logic [NUM_AUX*NUM_PINS-1:0]   aux_dir,
  input  logic [NUM_PINS-1:0]           strm_out,
  input  logic [NUM_PINS-1:0]           strm_dir,
  input  logic [NUM_PINS-1:0]           pin_in,
  input  logic [NUM_PINS-1:0]           in_smart_sel,
  input  logic [NUM_PINS-1:0]           smart_in,
  output logic [NUM_PINS-1:0]           pin_out,
  output logic [NUM_PINS-1:0]           pin_oe,
  output logic [NUM_CORES*NUM_PINS-1:0] rd_reg,
  output logic [NUM_CORES*NUM_PINS-1:0] rd_test
);
  localparam int P    = NUM_PINS;
  localparam int NSRC = NUM_CORES + NUM_AUX + 1;
  localparam int AUX0 = NUM_CORES * P;
  localparam int STR0 = (NUM_CORES + NUM_AUX) * P;

  logic [P-1:0]      in_fresh, in_hub;
  logic [NSRC*P-1:0] src_out, src_dir;
  logic [P-1:0]      merged_out, merged_dir;
  logic [P-1:0]      hub_out_q, hub_dir_q;

  pio_in_stage #(.W(P)) u_in (
    .clk      (clk),
    .rst      (rst),
    .pin_in   (pin_in),
    .sel      (in_smart_sel),
    .smart_in (smart_in),
    .mux_o    (in_fresh),
    .hub_q    (in_hub)
  );

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
    logic [P-1:0] oq, dq;
    pio_core_port #(.W(P)) u_port (
      .clk      (clk),
      .rst      (rst),
      .commit   (core_commit[g]),
      .begin_i  (core_begin[g]),
      .out_wr   (core_out_wr[g*P +: P]),
      .dir_wr   (core_dir_wr[g*P +: P]),
      .hub_in   (in_hub),
      .fresh_in (in_fresh),
      .out_q    (oq),
      .dir_q    (dq),
      .rd_reg   (rd_reg[g*P +: P]),
      .rd_test  (rd_test[g*P +: P])
    );
    assign src_out[g*P +: P] = oq;
    assign src_dir[g*P +: P] = dq;
  end

  assign src_out[AUX0 +: NUM_AUX*P] = aux_out;
  assign src_dir[AUX0 +: NUM_AUX*P] = aux_dir;
  assign src_out[STR0 +: P]         = strm_out;
  assign src_dir[STR0 +: P]         = strm_dir;

  pio_or_merge #(.W(P), .NSRC(NSRC)) u_or_out (.src(src_out), .merged(merged_out));
  pio_or_merge #(.W(P), .NSRC(NSRC)) u_or_dir (.src(src_dir), .merged(merged_dir));

  always_ff @(posedge clk) begin
    if (rst) begin
      hub_out_q <= '0;
      hub_dir_q <= '0;
    end else begin
      hub_out_q <= merged_out;
      hub_dir_q <= merged_dir;
    end
  end

  assign pin_out = hub_out_q;
  assign pin_oe  = hub_dir_q;
endmodule

// File: rtl/pio_pipeline_chk.sv
module pio_pipeline_chk #(
  parameter int NUM_CORES = 4,
  parameter int NUM_PINS  = 64,
  parameter int NUM_AUX   = 2
) (
  input logic                          clk,
  input logic                          rst,
  input logic [NUM_CORES-1:0]          core_commit,
  input logic [NUM_CORES-1:0]          core_begin,
  input logic [NUM_CORES*NUM_PINS-1:0] core_dir_wr,
  input logic [NUM_AUX*NUM_PINS-1:0]   aux_out,
  input logic [NUM_PINS-1:0]           strm_out,
  input logic [NUM_PINS-1:0]           pin_out,
  input logic [NUM_PINS-1:0]           pin_oe,
  input logic [NUM_CORES*NUM_PINS-1:0] rd_reg,
  input logic [NUM_CORES*NUM_PINS-1:0] rd_test
);
  localparam int P = NUM_PINS;

  logic [1:0] run_cnt;
  logic       warm;
  logic       rst_d;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst)                  run_cnt <= 2'd0;
    else if (run_cnt != 2'd2) run_cnt <= run_cnt + 2'd1;
  end
  assign warm = (run_cnt == 2'd2);

  always @(negedge clk) begin
    if (rst_d) begin
      assert_reset_idle_R1: assert (pin_out == '0 && pin_oe == '0 && rd_reg == '0 && rd_test == '0)
        else $error("reset did not clear pipeline");
    end
  end

  assert_pins_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (warm && $past(core_commit) == '0 && $stable(aux_out) && $stable(strm_out)) |=> $stable(pin_out));

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_chk
    assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
      (warm && $past(core_commit[g], 2)) |->
        ((pin_oe & $past(core_dir_wr[g*P +: P], 2)) == $past(core_dir_wr[g*P +: P], 2)));

    assert_reg_hold_R6: assert property (@(posedge clk) disable iff (rst)
      (warm && !$past(core_commit[g])) |-> $stable(rd_reg[g*P +: P]));

    assert_test_hold_R7: assert property (@(posedge clk) disable iff (rst)
      (warm && !$past(core_begin[g])) |-> $stable(rd_test[g*P +: P]));
  end
endmodule

bind pio_pipeline pio_pipeline_chk #(
  .NUM_CORES(NUM_CORES), .NUM_PINS(NUM_PINS), .NUM_AUX(NUM_AUX)
) u_chk (
  .clk(clk), .rst(rst), .core_commit(core_commit), .core_begin(core_begin),
  .core_dir_wr(core_dir_wr), .aux_out(aux_out), .strm_out(strm_out),
  .pin_out(pin_out), .pin_oe(pin_oe), .rd_reg(rd_reg), .rd_test(rd_test)
);

// File: tb/pio_pipeline_tb.sv
module pio_pipeline_tb_top;
  localparam int NC = 4;
  localparam int P  = 64;
  localparam int NA = 2;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NC-1:0]   core_commit = '0, core_begin = '0;
  logic [NC*P-1:0] core_out_wr = '0, core_dir_wr = '0;
  logic [NA*P-1:0] aux_out = '0, aux_dir = '0;
  logic [P-1:0]    strm_out = '0, strm_dir = '0;
  logic [P-1:0]    pin_in = '0, in_smart_sel = '0, smart_in = '0;
  logic [P-1:0]    pin_out, pin_oe;
  logic [NC*P-1:0] rd_reg, rd_test;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  pio_pipeline #(.NUM_CORES(NC), .NUM_PINS(P), .NUM_AUX(NA)) dut_i (
    .clk(clk), .rst(rst), .core_commit(core_commit), .core_begin(core_begin),
    .core_out_wr(core_out_wr), .core_dir_wr(core_dir_wr), .aux_out(aux_out),
    .aux_dir(aux_dir), .strm_out(strm_out), .strm_dir(strm_dir), .pin_in(pin_in),
    .in_smart_sel(in_smart_sel), .smart_in(smart_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .rd_reg(rd_reg), .rd_test(rd_test)
  );

  // Reference model built from the requirement timings
  logic [P-1:0] m_co [NC];
  logic [P-1:0] m_cd [NC];
  logic [P-1:0] m_rr [NC];
  logic [P-1:0] m_rt [NC];
  logic [P-1:0] m_pad, m_hub, m_po, m_pe;

  function automatic logic [P-1:0] f_sel(input logic [P-1:0] pad, input logic [P-1:0] sel,
                                         input logic [P-1:0] sm);
    return (pad & ~sel) | (sm & sel);
  endfunction

  function automatic logic [P-1:0] f_or_out();
    logic [P-1:0] r = strm_out;
    for (int i = 0; i < NC; i++) r |= m_co[i];
    for (int a = 0; a < NA; a++) r |= aux_out[a*P +: P];
    return r;
  endfunction

  function automatic logic [P-1:0] f_or_dir();
    logic [P-1:0] r = strm_dir;
    for (int i = 0; i < NC; i++) r |= m_cd[i];
    for (int a = 0; a < NA; a++) r |= aux_dir[a*P +: P];
    return r;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NC; i++) begin
        m_co[i] <= '0; m_cd[i] <= '0; m_rr[i] <= '0; m_rt[i] <= '0;
      end
      m_pad <= '0; m_hub <= '0; m_po <= '0; m_pe <= '0;
    end else begin
      for (int i = 0; i < NC; i++) begin
        if (core_commit[i]) begin
          m_co[i] <= core_out_wr[i*P +: P];
          m_cd[i] <= core_dir_wr[i*P +: P];
          m_rr[i] <= m_hub;
        end
        if (core_begin[i]) m_rt[i] <= f_sel(m_pad, in_smart_sel, smart_in);
      end
      m_pad <= pin_in;
      m_hub <= f_sel(m_pad, in_smart_sel, smart_in);
      m_po  <= f_or_out();
      m_pe  <= f_or_dir();
    end
  end

  task automatic chk(input string tag, input logic [P-1:0] act, input logic [P-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  function automatic logic [P-1:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [P-1:0] w1, w2, pv, old;
    logic [31:0]  r;
    void'($urandom(32'd20231));

    // R1: reset wins over active inputs
    @(negedge clk);
    core_commit = '1; core_begin = '1;
    core_out_wr = '1; core_dir_wr = '1; pin_in = '1;
    step(2);
    chk("R1 pin_out in reset", pin_out, '0);
    chk("R1 pin_oe in reset", pin_oe, '0);
    chk("R1 rd_reg in reset", rd_reg[P-1:0], '0);
    chk("R1 rd_test in reset", rd_test[P-1:0], '0);
    core_commit = '0; core_begin = '0; core_out_wr = '0; core_dir_wr = '0; pin_in = '0;
    step(1);
    rst = 1'b0;
    step(3);
    chk("R1 idle after reset", pin_oe, '0);

    // R2: core 1 write lands after the second rising edge
    w1 = 64'hA5A5_0000_FFFF_0001;
    core_out_wr[1*P +: P] = w1; core_dir_wr[1*P +: P] = ~w1; core_commit[1] = 1'b1;
    step(1);
    core_commit[1] = 1'b0;
    chk("R2 pin_out not yet", pin_out, '0);
    step(1);
    chk("R2 pin_out due", pin_out, w1);
    chk("R2 pin_oe due", pin_oe, ~w1);

    // R3: words without commit are ignored
    core_out_wr = '1; core_dir_wr = '0;
    step(4);
    chk("R3 pin_out held", pin_out, w1);
    chk("R3 pin_oe held", pin_oe, ~w1);

    // R4: OR of two cores committing together
    w2 = 64'h0F0F_1234_0000_8000;
    core_out_wr[0*P +: P] = w2; core_out_wr[2*P +: P] = 64'h10;
    core_dir_wr[0*P +: P] = w2; core_dir_wr[2*P +: P] = 64'h20;
    core_commit = 4'b0101;
    step(1);
    core_commit = '0;
    step(1);
    chk("R4 merged pin_out", pin_out, w1 | w2 | 64'h10);
    chk("R4 merged pin_oe", pin_oe, ~w1 | w2 | 64'h20);

    // R5: aux and streamer words land after one edge
    aux_out[1*P +: P] = 64'h8000_0000_0000_0000;
    strm_dir = 64'h1;
    step(1);
    chk("R5 aux on pin_out", pin_out, w1 | w2 | 64'h10 | 64'h8000_0000_0000_0000);
    chk("R5 streamer on pin_oe", pin_oe, ~w1 | w2 | 64'h20 | 64'h1);
    aux_out = '0; strm_dir = '0;

    // R6, R7: input latencies with strobes held high on core 0
    core_commit[0] = 1'b1; core_begin[0] = 1'b1;
    core_out_wr = '0; core_dir_wr = '0;
    step(4);
    pv = 64'hDEAD_BEEF_0BAD_F00D;
    pin_in = pv;
    step(1);
    chk("R7 rd_test not yet", rd_test[0 +: P], '0);
    step(1);
    chk("R7 rd_test due at 2", rd_test[0 +: P], pv);
    chk("R6 rd_reg not yet", rd_reg[0 +: P], '0);
    step(1);
    chk("R6 rd_reg due at 3", rd_reg[0 +: P], pv);

    // R6, R7: strobes low hold both ports
    core_commit[0] = 1'b0; core_begin[0] = 1'b0;
    pin_in = ~pv;
    step(5);
    chk("R6 rd_reg holds", rd_reg[0 +: P], pv);
    chk("R7 rd_test holds", rd_test[0 +: P], pv);

    // R8: per-pin bypass mux
    core_commit[3] = 1'b1; core_begin[3] = 1'b1;
    pin_in = 64'h0000_FFFF_0000_FFFF;
    smart_in = 64'hFFFF_FFFF_0000_0000;
    in_smart_sel = 64'hFF00_FF00_FF00_FF00;
    step(3);
    chk("R8 rd_reg mux", rd_reg[3*P +: P], 64'hFF00_FFFF_0000_00FF);
    chk("R8 rd_test mux", rd_test[3*P +: P], 64'hFF00_FFFF_0000_00FF);
    core_commit = '0; core_begin = '0;

    // Random phase against the model (R4, R6, R7)
    for (int c = 0; c < 3000; c++) begin
      chk("R4 random pin_out", pin_out, m_po);
      chk("R4 random pin_oe", pin_oe, m_pe);
      for (int i = 0; i < NC; i++) begin
        chk("R6 random rd_reg", rd_reg[i*P +: P], m_rr[i]);
        chk("R7 random rd_test", rd_test[i*P +: P], m_rt[i]);
      end
      r = $urandom();
      core_commit = r[NC-1:0];
      core_begin  = r[NC+3:4];
      for (int i = 0; i < NC; i++) begin
        core_out_wr[i*P +: P] = rnd64() & rnd64();
        core_dir_wr[i*P +: P] = rnd64() & rnd64() & rnd64();
      end
      if (r[8])  aux_out = {rnd64() & rnd64(), rnd64() & rnd64()};
      if (r[9])  aux_dir = {rnd64() & rnd64(), rnd64() & rnd64()};
      if (r[10]) strm_out = rnd64() & rnd64() & rnd64();
      if (r[11]) strm_dir = rnd64() & rnd64() & rnd64();
      pin_in = rnd64();
      smart_in = rnd64();
      if (r[12]) in_smart_sel = rnd64();
      old = pin_out;
      step(1);
    end
    finish_run();
  end
endmodule